// File: doc/BRIEF.md
# Comparator Peripheral Control Logic

This block is the digital side of an on-chip voltage comparator. Software programs a control register that turns the comparator on, chooses where its positive input comes from, decides whether the result drives an output pin, and picks which result edge raises an interrupt. From those bits the block drives the pin-mux selects for the negative-input, positive-input and output pins, and a tap code for the internal reference ladder. The analog comparator and the ladder sit outside the block.

The comparator result enters as an asynchronous bit. It passes through a two-flop synchronizer and appears, unlatched, as a readable status flag. The selected edge of the synchronized result sets a sticky interrupt flag. That flag stays set until software writes a zero to it. A simple single-cycle register bus gives access to one control register and one status register.

Top module: `cmpw_top`

## Requirements
- R1: After reset, every control bit reads 0, all three pin selects are 0 (GPIO), the reference tap is 0, `cmpEnable` is 0 and the interrupt flag is 0.
- R2: With control bit 7 (enable) at 0, `cmpEnable`, `negPinCmp`, `posPinCmp` and `outPinCmp` are all 0 and `refTap` is 0. With enable at 1, `cmpEnable` and `negPinCmp` are 1.
- R3: With enable at 1, reference select (control bits 2:0) of 000 sets `posPinCmp`=1 and `refTap`=0. Any code from 001 to 111 sets `posPinCmp`=0 and `refTap` equal to the code. Code n selects the internal level (n+1)/10 of the supply.
- R4: With enable at 1 and output-enable (control bit 6) at 1, `outPinCmp`=1 and `cmpOutPin` follows the synchronized result. In every other case `outPinCmp`=0 and `cmpOutPin`=0.
- R5: Status bit 0 shows the comparator input two clocks after it changes, without latching. It reads 0 while enable is 0.
- R6: The interrupt flag (status bit 1, also on `irqOut`) stays set until a write to the status register (address 1) carries 0 in bit 1. A write with 1 in bit 1 leaves the flag unchanged.
- R7: With edge-select (control bit 5) at 0, only a high-to-low change of the synchronized result sets the interrupt. With edge-select at 1, only a low-to-high change sets it. The flag is set on the clock after the change reaches status bit 0.
- R8: While enable is 0, no change of the input sets the interrupt. Turning enable on while the input is already high does not set it, even with rising edge selected.
- R9: When a clearing write and a qualifying edge occur in the same cycle, the interrupt flag ends up set.
- R10: The control register is at address 0, with bits 4:3 reading 0. The status register is at address 1, with bits 7:2 reading 0. A read returns data in the same cycle as the address is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe, one cycle |
| regAddr | input | 1 | Register address: 0 control, 1 status |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data for `regAddr`, combinational |
| cmpRawIn | input | 1 | Asynchronous result from the analog comparator |
| cmpEnable | output | 1 | Powers the analog comparator |
| negPinCmp | output | 1 | 1: negative-input pin routed to the comparator |
| posPinCmp | output | 1 | 1: positive-input pin routed to the comparator |
| outPinCmp | output | 1 | 1: output pin driven by the comparator instead of GPIO |
| cmpOutPin | output | 1 | Value for the output pin when it is muxed to the comparator |
| refTap | output | 3 | Internal reference tap code, 0 when the external pin is used |
| irqOut | output | 1 | Sticky interrupt flag |

## Verification
The assertions assume that `cmpRawIn` can change at any time, but that no two changes arrive closer together than the synchronizer depth. Under that assumption each transition of the synchronized result is a clean single-cycle edge. They also assume that reset is held long enough to clear the synchronizer. The bench changes `cmpRawIn` only on falling clock edges and holds each level for at least three clocks before it checks. The one exception is the coincidence test, where the edge is lined up on purpose with the clearing write.

// File: rtl/cmpw_pkg.sv
package cmpw_pkg;
  localparam int DATA_W   = 8;
  localparam int REF_W    = 3;
  localparam int EN_BIT   = 7;
  localparam int OE_BIT   = 6;
  localparam int EDGE_BIT = 5;
  localparam int RES_BIT  = 0;
  localparam int IRQ_BIT  = 1;

  typedef struct packed {
    logic enable;
    logic edgeRise;
    logic irqClr;
  } cmpStrobe_t;
endpackage

// File: rtl/cmpw_dpath.sv
module cmpw_dpath
  import cmpw_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmpRawIn,
  input  cmpStrobe_t stb,
  output logic       syncVal,
  output logic       irqFlag
);
  logic [SYNC_STAGES-1:0] syncChain;
  logic prevVal;
  logic edgeHit;

  generate
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) syncChain[0] <= 1'b0;
          else       syncChain[0] <= cmpRawIn;
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN)
          if (!rstN) syncChain[i] <= 1'b0;
          else       syncChain[i] <= syncChain[i-1];
      end
    end
  endgenerate

  assign syncVal = syncChain[SYNC_STAGES-1];

  // History tracks always, so enabling never sees a stale reset value.
  always_ff @(posedge clk or negedge rstN)
    if (!rstN) prevVal <= 1'b0;
    else       prevVal <= syncVal;

  always_comb begin
    if (stb.edgeRise) edgeHit = stb.enable & syncVal & ~prevVal;
    else              edgeHit = stb.enable & ~syncVal & prevVal;
  end

  // Set wins over clear.
  always_ff @(posedge clk or negedge rstN)
    if (!rstN)           irqFlag <= 1'b0;
    else if (edgeHit)    irqFlag <= 1'b1;
    else if (stb.irqClr) irqFlag <= 1'b0;

  a_r6_irq_sticky: assert property (@(posedge clk) disable iff (!rstN)
    irqFlag && !stb.irqClr |=> irqFlag);
  a_r7_rise_sets: assert property (@(posedge clk) disable iff (!rstN)
    stb.enable && stb.edgeRise && $rose(syncVal) |=> irqFlag);
  a_r7_fall_sets: assert property (@(posedge clk) disable iff (!rstN)
    stb.enable && !stb.edgeRise && $fell(syncVal) |=> irqFlag);
  a_r8_quiet_when_off: assert property (@(posedge clk) disable iff (!rstN)
    !stb.enable && !irqFlag |=> !irqFlag);
  a_r9_set_beats_clear: assert property (@(posedge clk) disable iff (!rstN)
    stb.irqClr && stb.enable && stb.edgeRise && $rose(syncVal) |=> irqFlag);
endmodule

// File: rtl/cmpw_ctrl.sv
module cmpw_ctrl
  import cmpw_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic              syncVal,
  input  logic              irqFlag,
  output cmpStrobe_t        stb,
  output logic              cmpEnable,
  output logic              negPinCmp,
  output logic              posPinCmp,
  output logic              outPinCmp,
  output logic              cmpOutPin,
  output logic [REF_W-1:0]  refTap
);
  logic             enBit, oeBit, edgeBit;
  logic [REF_W-1:0] refSel;
  logic             ctrlWr, statWr;

  assign ctrlWr = regWrEn && (regAddr == 1'b0);
  assign statWr = regWrEn && (regAddr == 1'b1);

  always_ff @(posedge clk or negedge rstN)
    if (!rstN) begin
      enBit   <= 1'b0;
      oeBit   <= 1'b0;
      edgeBit <= 1'b0;
      refSel  <= '0;
    end else if (ctrlWr) begin
      enBit   <= regWrData[EN_BIT];
      oeBit   <= regWrData[OE_BIT];
      edgeBit <= regWrData[EDGE_BIT];
      refSel  <= regWrData[REF_W-1:0];
    end

  always_comb begin
    stb.enable   = enBit;
    stb.edgeRise = edgeBit;
    stb.irqClr   = statWr && !regWrData[IRQ_BIT];
  end

  assign cmpEnable = enBit;
  assign negPinCmp = enBit;
  assign posPinCmp = enBit && (refSel == '0);
  assign refTap    = enBit ? refSel : '0;
  assign outPinCmp = enBit && oeBit;
  assign cmpOutPin = enBit && oeBit && syncVal;

  always_comb begin
    regRdData = '0;
    if (regAddr == 1'b0) begin
      regRdData[EN_BIT]      = enBit;
      regRdData[OE_BIT]      = oeBit;
      regRdData[EDGE_BIT]    = edgeBit;
      regRdData[REF_W-1:0]   = refSel;
    end else begin
      regRdData[RES_BIT] = enBit && syncVal;
      regRdData[IRQ_BIT] = irqFlag;
    end
  end

  a_r2_gpio_when_off: assert property (@(posedge clk) disable iff (!rstN)
    !cmpEnable |-> !posPinCmp && !outPinCmp && refTap == '0);
  a_r3_one_pos_source: assert property (@(posedge clk) disable iff (!rstN)
    posPinCmp |-> refTap == '0);
  a_r4_pin_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !outPinCmp |-> !cmpOutPin);
endmodule

// File: rtl/cmpw_top.sv
module cmpw_top
  import cmpw_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic             regAddr,
  input  logic [7:0]       regWrData,
  output logic [7:0]       regRdData,
  input  logic             cmpRawIn,
  output logic             cmpEnable,
  output logic             negPinCmp,
  output logic             posPinCmp,
  output logic             outPinCmp,
  output logic             cmpOutPin,
  output logic [2:0]       refTap,
  output logic             irqOut
);
  cmpStrobe_t stb;
  logic syncVal, irqFlag;

  cmpw_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .syncVal(syncVal),
    .irqFlag(irqFlag), .stb(stb), .cmpEnable(cmpEnable),
    .negPinCmp(negPinCmp), .posPinCmp(posPinCmp), .outPinCmp(outPinCmp),
    .cmpOutPin(cmpOutPin), .refTap(refTap)
  );

  cmpw_dpath #(.SYNC_STAGES(SYNC_STAGES)) u_dpath (
    .clk(clk), .rstN(rstN), .cmpRawIn(cmpRawIn), .stb(stb),
    .syncVal(syncVal), .irqFlag(irqFlag)
  );

  assign irqOut = irqFlag;
endmodule

// File: tb/tb_cmpw_top.sv
module tb_cmpw_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic regAddr = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic cmpRawIn = 1'b0;
  logic cmpEnable, negPinCmp, posPinCmp, outPinCmp, cmpOutPin, irqOut;
  logic [2:0] refTap;

  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cmpw_top dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .cmpRawIn(cmpRawIn),
    .cmpEnable(cmpEnable), .negPinCmp(negPinCmp), .posPinCmp(posPinCmp),
    .outPinCmp(outPinCmp), .cmpOutPin(cmpOutPin), .refTap(refTap),
    .irqOut(irqOut)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic setIn(input logic v);
    @(negedge clk);
    cmpRawIn = v;
    repeat (3) @(posedge clk);
  endtask

  task automatic testReset();
    logic [7:0] d;
    rd(1'b0, d); chk("R1 ctrl", d, 8'h00);
    rd(1'b1, d); chk("R1 stat", d, 8'h00);
    chk("R1 pins", {3'b0, cmpEnable, negPinCmp, posPinCmp, outPinCmp, irqOut}, 8'h00);
    chk("R1 tap", {5'b0, refTap}, 8'h00);
  endtask

  task automatic testPinMux();
    logic [7:0] d;
    wr(1'b0, 8'h1F);
    @(negedge clk);
    chk("R2 off", {4'b0, cmpEnable, negPinCmp, posPinCmp, outPinCmp}, 8'h00);
    chk("R2 off tap", {5'b0, refTap}, 8'h00);
    rd(1'b0, d); chk("R10 bits 4:3 read 0", d, 8'h07);
    for (int c = 0; c < 8; c++) begin
      wr(1'b0, 8'h80 | 8'(c));
      @(negedge clk);
      chk("R2 on", {6'b0, cmpEnable, negPinCmp}, 8'h03);
      chk("R3 pos sel", {7'b0, posPinCmp}, (c == 0) ? 8'h01 : 8'h00);
      chk("R3 tap", {5'b0, refTap}, 8'(c));
    end
  endtask

  task automatic testOutPin();
    wr(1'b0, 8'h40);
    setIn(1'b1);
    @(negedge clk);
    chk("R4 off no mux", {6'b0, outPinCmp, cmpOutPin}, 8'h00);
    wr(1'b0, 8'hC0);
    @(negedge clk);
    chk("R4 mux high", {6'b0, outPinCmp, cmpOutPin}, 8'h03);
    setIn(1'b0);
    @(negedge clk);
    chk("R4 mux low", {6'b0, outPinCmp, cmpOutPin}, 8'h02);
    wr(1'b0, 8'h80);
    setIn(1'b1);
    @(negedge clk);
    chk("R4 oe off", {6'b0, outPinCmp, cmpOutPin}, 8'h00);
    setIn(1'b0);
  endtask

  task automatic testStatus();
    logic [7:0] d;
    wr(1'b0, 8'hA0);
    wr(1'b1, 8'h00);
    @(negedge clk); cmpRawIn = 1'b1;
    @(posedge clk);
    rd(1'b1, d); chk("R5 one clock", {7'b0, d[0]}, 8'h00);
    @(posedge clk);
    rd(1'b1, d); chk("R5 two clocks", {7'b0, d[0]}, 8'h01);
    @(negedge clk); cmpRawIn = 1'b0;
    repeat (2) @(posedge clk);
    rd(1'b1, d); chk("R5 unlatched", {7'b0, d[0]}, 8'h00);
    chk("R10 stat upper", {2'b0, d[7:2]}, 8'h00);
    wr(1'b1, 8'h00);
  endtask

  task automatic testFalling();
    logic [7:0] d;
    wr(1'b0, 8'h80);
    setIn(1'b1);
    wr(1'b1, 8'h00);
    @(negedge clk); chk("R7 rise ignored", {7'b0, irqOut}, 8'h00);
    @(negedge clk); cmpRawIn = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk); chk("R7 not yet", {7'b0, irqOut}, 8'h00);
    @(posedge clk);
    @(negedge clk); chk("R7 fall sets", {7'b0, irqOut}, 8'h01);
    wr(1'b1, 8'h02);
    rd(1'b1, d); chk("R6 write 1 keeps", {7'b0, d[1]}, 8'h01);
    repeat (5) @(posedge clk);
    @(negedge clk); chk("R6 sticky", {7'b0, irqOut}, 8'h01);
    wr(1'b1, 8'h00);
    @(negedge clk); chk("R6 cleared", {7'b0, irqOut}, 8'h00);
  endtask

  task automatic testRising();
    wr(1'b0, 8'hA0);
    setIn(1'b1);
    @(negedge clk); chk("R7 rise sets", {7'b0, irqOut}, 8'h01);
    wr(1'b1, 8'h00);
    setIn(1'b0);
    @(negedge clk); chk("R7 fall ignored", {7'b0, irqOut}, 8'h00);
  endtask

  task automatic testDisabled();
    logic [7:0] d;
    wr(1'b0, 8'h20);
    wr(1'b1, 8'h00);
    setIn(1'b1);
    setIn(1'b0);
    setIn(1'b1);
    @(negedge clk); chk("R8 off no irq", {7'b0, irqOut}, 8'h00);
    rd(1'b1, d); chk("R5 off reads 0", {7'b0, d[0]}, 8'h00);
    wr(1'b0, 8'hA0);
    repeat (3) @(posedge clk);
    @(negedge clk); chk("R8 enable no spurious", {7'b0, irqOut}, 8'h00);
    setIn(1'b0);
  endtask

  task automatic testRace();
    wr(1'b0, 8'hA0);
    setIn(1'b1);
    setIn(1'b0);
    @(negedge clk); chk("R9 preset", {7'b0, irqOut}, 8'h01);
    cmpRawIn = 1'b1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = 1'b1; regWrData = 8'h00;
    @(negedge clk);
    regWrEn = 1'b0;
    chk("R9 set wins", {7'b0, irqOut}, 8'h01);
    wr(1'b1, 8'h00);
    @(negedge clk); chk("R9 later clear", {7'b0, irqOut}, 8'h00);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    testReset();
    testPinMux();
    testOutPin();
    testStatus();
    testFalling();
    testRising();
    testDisabled();
    testRace();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        nChecks++; nFails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule